// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM audio from a three-wire serial link (a bit clock, a left/right frame clock and a data line) and turns it into parallel 24-bit two's complement samples. The three link pins are sampled with a fast system clock through a short synchronizer. Each rising edge of the bit clock is found there and one data bit is taken on that edge. A 2-bit format input picks one of four frame layouts: left-justified, I2S, and right-justified with 16-bit or 24-bit words. All four share one datapath.

A channel half ends when the frame clock level seen on a bit-clock rise differs from the level on the rise before it. The word of the half that just ended is then taken from one of two places. For the formats that start at the frame edge, it comes from a window register filled by bit position. For the right-justified formats, it comes from a register that always holds the most recent bits. A left word is held until the following right word is complete. Both then appear together with a one-cycle valid strobe, so the two channels of a frame leave the block at the same moment.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high and in the first cycle after it, `pairValid` is 0 and both sample outputs are 0.
- R2: With `fmtSel` = 0 (left-justified), the bit taken on the first bit-clock rise after a frame clock change is the MSB, bit 23. The next 23 rises supply bits 22 down to 0. A frame clock high half is the left channel.
- R3: With `fmtSel` = 1 (I2S), the bit on the first rise after a frame clock change is skipped. The MSB is taken on the second rise and 24 bits follow MSB first. A frame clock low half is the left channel.
- R4: With `fmtSel` = 3 (right-justified, 24-bit), the word is the last 24 bits before the frame clock changes, MSB first. Bits earlier in the half are ignored. A high half is left.
- R5: With `fmtSel` = 2 (right-justified, 16-bit), the word is the last 16 bits before the frame clock changes, sign-extended from bit 15 to 24 bits. A high half is left.
- R6: A left half followed by a right half is output as one pair, with `pairValid` high for a single cycle. A right half that has no left half before it produces no output.
- R7: After reset, the half that is in progress when the first frame clock change is seen is discarded, because its start was not observed.
- R8: In the left-justified and I2S formats, bits beyond the 24th data bit of a half are ignored.
- R9: `leftData` and `rightData` change only in a cycle where `pairValid` is high, and `pairValid` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous reset, active high |
| fmtSel | input | 2 | Frame format: 0 left-justified, 1 I2S, 2 right-justified 16-bit, 3 right-justified 24-bit |
| sclkIn | input | 1 | Serial bit clock; data is taken on its rising edge |
| lrIn | input | 1 | Frame (left/right) clock |
| sdIn | input | 1 | Serial data, MSB first |
| pairValid | output | 1 | One-cycle strobe marking a new left/right pair |
| leftData | output | 24 | Left sample of the latest pair |
| rightData | output | 24 | Right sample of the latest pair |

## Verification
Each format receives two frames. The samples mix MSB-set and MSB-clear words, and every slot that carries no data is driven with ones. This shows whether the MSB alignment is off by one bit clock, whether unused slots leak into the word, and whether the channel polarity of the frame clock is swapped. The 16-bit right-justified run uses one negative and one positive word, which tells sign extension apart from zero fill. A separate run starts in the middle of a left half and then sends a right half with nothing before it. It confirms that the partial half and the unmatched right half are both dropped, and that the next proper pair still appears.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_IDX_W = 5;

  typedef enum logic [1:0] {
    FMT_LEFTJ = 2'd0,
    FMT_I2S   = 2'd1,
    FMT_RJ16  = 2'd2,
    FMT_RJ24  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic                  bitStb;
    logic                  halfStart;
    logic                  slotWrite;
    logic [SLOT_IDX_W-1:0] slotPos;
    logic                  wordDone;
    logic                  doneIsLeft;
  } rx_strobe_t;
endpackage

// File: rtl/serial_audio_rx_ctrl.sv
module serial_audio_rx_ctrl
  import serial_audio_rx_pkg::*;
#(
  parameter int DATA_W = SAMPLE_W,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  fmt_e       fmt,
  input  logic       sclkIn,
  input  logic       lrIn,
  input  logic       sdIn,
  output logic       dataBit,
  output rx_strobe_t stb
);
  localparam logic [SLOT_IDX_W-1:0] IDX_MAX = '1;
  localparam logic [SLOT_IDX_W-1:0] DATA_LAST = SLOT_IDX_W'(DATA_W - 1);
  localparam logic [SLOT_IDX_W-1:0] DATA_CNT = SLOT_IDX_W'(DATA_W);

  logic [SYNC_N:0]   sclkSync;
  logic [SYNC_N-1:0] lrSync;
  logic [SYNC_N-1:0] sdSync;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkSync <= '0;
      lrSync   <= '0;
      sdSync   <= '0;
    end else begin
      sclkSync <= {sclkSync[SYNC_N-1:0], sclkIn};
      lrSync   <= {lrSync[SYNC_N-2:0], lrIn};
      sdSync   <= {sdSync[SYNC_N-2:0], sdIn};
    end
  end

  logic lrNow;
  logic riseNow;
  assign lrNow   = lrSync[SYNC_N-1];
  assign dataBit = sdSync[SYNC_N-1];
  assign riseNow = sclkSync[SYNC_N-1] & ~sclkSync[SYNC_N];

  logic                  primed;
  logic                  prevLr;
  logic                  inHalf;
  logic [SLOT_IDX_W-1:0] bitIdx;
  logic [SLOT_IDX_W-1:0] idxNow;
  logic                  edgeNow;
  logic                  isI2s;

  always_comb begin
    isI2s   = (fmt == FMT_I2S);
    edgeNow = riseNow && primed && (lrNow != prevLr);
    if (edgeNow)               idxNow = '0;
    else if (bitIdx == IDX_MAX) idxNow = IDX_MAX;
    else                        idxNow = bitIdx + 1'b1;

    stb.bitStb     = riseNow;
    stb.halfStart  = edgeNow;
    stb.wordDone   = edgeNow && inHalf;
    stb.doneIsLeft = isI2s ? ~prevLr : prevLr;
    stb.slotPos    = isI2s ? idxNow - 1'b1 : idxNow;
    if (isI2s)
      stb.slotWrite = riseNow && (edgeNow || inHalf) && (idxNow != '0) && (idxNow <= DATA_CNT);
    else
      stb.slotWrite = riseNow && (edgeNow || inHalf) && (idxNow <= DATA_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      prevLr <= 1'b0;
      inHalf <= 1'b0;
      bitIdx <= '0;
    end else if (riseNow) begin
      primed <= 1'b1;
      prevLr <= lrNow;
      bitIdx <= idxNow;
      if (edgeNow) inHalf <= 1'b1;
    end
  end

  // R8: the slot counter saturates, so a long half never wraps into new data slots
  a_r8_idx_saturates: assert property (@(posedge clk) disable iff (rst)
    (riseNow && !edgeNow && bitIdx == IDX_MAX) |=> (bitIdx == IDX_MAX));

  // R7: no word completes before a frame clock change has started a half
  a_r7_first_half_dropped: assert property (@(posedge clk) disable iff (rst)
    (stb.wordDone) |-> (inHalf && primed));
endmodule

// File: rtl/serial_audio_rx_datapath.sv
module serial_audio_rx_datapath
  import serial_audio_rx_pkg::*;
#(
  parameter int DATA_W  = SAMPLE_W,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_e              fmt,
  input  logic              dataBit,
  input  rx_strobe_t        stb,
  output logic              pairValid,
  output logic [DATA_W-1:0] leftData,
  output logic [DATA_W-1:0] rightData
);
  localparam int EXT_W = DATA_W - SHORT_W;

  logic [DATA_W-1:0] winReg;
  logic [DATA_W-1:0] winNext;
  logic [DATA_W-1:0] tailReg;
  logic [DATA_W-1:0] leftHold;
  logic              haveLeft;
  logic [DATA_W-1:0] doneWord;

  always_comb begin
    winNext = stb.halfStart ? '0 : winReg;
    if (stb.slotWrite)
      winNext[DATA_W-1-int'(stb.slotPos)] = dataBit;
  end

  always_comb begin
    case (fmt)
      FMT_RJ24: doneWord = tailReg;
      FMT_RJ16: doneWord = {{EXT_W{tailReg[SHORT_W-1]}}, tailReg[SHORT_W-1:0]};
      default:  doneWord = winReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winReg    <= '0;
      tailReg   <= '0;
      leftHold  <= '0;
      haveLeft  <= 1'b0;
      pairValid <= 1'b0;
      leftData  <= '0;
      rightData <= '0;
    end else begin
      pairValid <= 1'b0;
      if (stb.bitStb) begin
        winReg  <= winNext;
        tailReg <= {tailReg[DATA_W-2:0], dataBit};
      end
      if (stb.wordDone) begin
        if (stb.doneIsLeft) begin
          leftHold <= doneWord;
          haveLeft <= 1'b1;
        end else begin
          haveLeft <= 1'b0;
          if (haveLeft) begin
            leftData  <= leftHold;
            rightData <= doneWord;
            pairValid <= 1'b1;
          end
        end
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!pairValid && leftData == '0));

  a_r6_pair_released: assert property (@(posedge clk) disable iff (rst)
    (stb.wordDone && !stb.doneIsLeft && haveLeft) |=> pairValid);

  a_r6_lone_right_dropped: assert property (@(posedge clk) disable iff (rst)
    (stb.wordDone && !stb.doneIsLeft && !haveLeft) |=> !pairValid);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pairValid |=> !pairValid);

  a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
    !pairValid |-> ($stable(leftData) && $stable(rightData)));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int DATA_W  = SAMPLE_W,
  parameter int SHORT_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmtSel,
  input  logic              sclkIn,
  input  logic              lrIn,
  input  logic              sdIn,
  output logic              pairValid,
  output logic [DATA_W-1:0] leftData,
  output logic [DATA_W-1:0] rightData
);
  fmt_e       fmt;
  logic       dataBit;
  rx_strobe_t stb;

  assign fmt = fmt_e'(fmtSel);

  serial_audio_rx_ctrl #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rst(rst), .fmt(fmt),
    .sclkIn(sclkIn), .lrIn(lrIn), .sdIn(sdIn),
    .dataBit(dataBit), .stb(stb)
  );

  serial_audio_rx_datapath #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_dp (
    .clk(clk), .rst(rst), .fmt(fmt),
    .dataBit(dataBit), .stb(stb),
    .pairValid(pairValid), .leftData(leftData), .rightData(rightData)
  );
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmtSel = 2'd0;
  logic        sclkIn = 1'b0;
  logic        lrIn = 1'b0;
  logic        sdIn = 1'b0;
  logic        pairValid;
  logic [23:0] leftData;
  logic [23:0] rightData;

  int testsRun = 0;
  int testsFailed = 0;
  int gotCnt = 0;
  int runLen = 0;
  int maxRun = 0;
  logic [23:0] gotL [4];
  logic [23:0] gotR [4];

  always #2.5 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst(rst), .fmtSel(fmtSel),
    .sclkIn(sclkIn), .lrIn(lrIn), .sdIn(sdIn),
    .pairValid(pairValid), .leftData(leftData), .rightData(rightData)
  );

  always @(negedge clk) begin
    if (rst) begin
      gotCnt = 0;
      runLen = 0;
    end else if (pairValid) begin
      if (gotCnt < 4) begin
        gotL[gotCnt] = leftData;
        gotR[gotCnt] = rightData;
      end
      gotCnt = gotCnt + 1;
      runLen = runLen + 1;
      if (runLen > maxRun) maxRun = runLen;
    end else begin
      runLen = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic slotBit(input int fmt, input int k, input logic [23:0] w);
    case (fmt)
      0: return (k < 24) ? w[23-k] : 1'b1;
      1: return (k >= 1 && k <= 24) ? w[24-k] : 1'b1;
      2: return (k >= 16) ? w[31-k] : 1'b1;
      default: return (k >= 8) ? w[31-k] : 1'b1;
    endcase
  endfunction

  function automatic logic [23:0] expWord(input int fmt, input logic [23:0] w);
    if (fmt == 2) return {{8{w[15]}}, w[15:0]};
    return w;
  endfunction

  task automatic bitOut(input logic lv, input logic d);
    sclkIn = 1'b0; lrIn = lv; sdIn = d;
    #20;
    sclkIn = 1'b1;
    #20;
  endtask

  task automatic sendHalf(input int fmt, input bit isLeft, input logic [23:0] w);
    logic lv;
    lv = (fmt == 1) ? !isLeft : isLeft;
    for (int k = 0; k < 32; k++) bitOut(lv, slotBit(fmt, k, w));
  endtask

  task automatic doReset(input int fmt);
    rst = 1'b1; fmtSel = 2'(fmt); sclkIn = 1'b0;
    repeat (6) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pairValid == 1'b0, "R1 valid in reset", 32'(pairValid), 0);
    check(leftData == 24'h0 && rightData == 24'h0, "R1 outputs in reset", 32'(leftData), 0);
    #1 rst = 1'b0;
    @(negedge clk);
    check(pairValid == 1'b0, "R1 valid after reset", 32'(pairValid), 0);
  endtask

  task automatic testFormat(input int fmt, input string req,
                            input logic [23:0] l0, input logic [23:0] r0,
                            input logic [23:0] l1, input logic [23:0] r1);
    logic lLv;
    doReset(fmt);
    lLv = (fmt == 1) ? 1'b0 : 1'b1;
    bitOut(!lLv, 1'b1); bitOut(!lLv, 1'b1);
    sendHalf(fmt, 1, l0); sendHalf(fmt, 0, r0);
    sendHalf(fmt, 1, l1); sendHalf(fmt, 0, r1);
    bitOut(lLv, 1'b0); bitOut(lLv, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(gotCnt == 2, {req, " pair count (R6)"}, 32'(gotCnt), 2);
    check(gotL[0] == expWord(fmt, l0), {req, " left 0 (R8)"}, 32'(gotL[0]), 32'(expWord(fmt, l0)));
    check(gotR[0] == expWord(fmt, r0), {req, " right 0"}, 32'(gotR[0]), 32'(expWord(fmt, r0)));
    check(gotL[1] == expWord(fmt, l1), {req, " left 1"}, 32'(gotL[1]), 32'(expWord(fmt, l1)));
    check(gotR[1] == expWord(fmt, r1), {req, " right 1"}, 32'(gotR[1]), 32'(expWord(fmt, r1)));
  endtask

  task automatic testLoneRight();
    doReset(0);
    bitOut(1'b1, 1'b1); bitOut(1'b1, 1'b0); bitOut(1'b1, 1'b1);
    sendHalf(0, 0, 24'h5A5A5A);
    sendHalf(0, 1, 24'h135790);
    sendHalf(0, 0, 24'hFEDCBA);
    bitOut(1'b1, 1'b0); bitOut(1'b1, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(gotCnt == 1, "R6 R7 lone right and partial half dropped", 32'(gotCnt), 1);
    check(gotL[0] == 24'h135790, "R6 left of surviving pair", 32'(gotL[0]), 32'h135790);
    check(gotR[0] == 24'hFEDCBA, "R6 right of surviving pair", 32'(gotR[0]), 32'hFEDCBA);
  endtask

  initial begin : watchdog
    #2000000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testFormat(0, "R2 left-justified", 24'h9A5C31, 24'h1234AB, 24'h7FFFFF, 24'h800001);
    testFormat(1, "R3 I2S", 24'hC0FFEE, 24'h012345, 24'h800000, 24'h3C3C3C);
    testFormat(3, "R4 rj24", 24'hA1B2C3, 24'h0F0F0F, 24'h7654FE, 24'hFFFFFE);
    testFormat(2, "R5 rj16", 24'h008001, 24'h007ABC, 24'h00FFFF, 24'h000100);
    testLoneRight();
    check(maxRun == 1, "R9 valid pulse width", 32'(maxRun), 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule